// File: doc/BRIEF.md
# Register Access Command Sequencer

This block sits between a requester issuing register and block transfers and a serial shift engine that moves whole words on the wire. For each accepted request it checks the length and builds the 32-bit command header. It then works out how many bytes the engine sends and how many it receives, and starts the engine. When the engine finishes, the block returns the last received word, or an error flag, on a one-cycle response strobe.

Reads on the backplane function need extra padding bytes before the response word. The block adds that padding to the receive length. Writes to the data function are held back until the bus status register reports that function ready. The block polls that register with status reads, up to a bounded number of attempts, and fails the request if the limit is reached. A boot-swap input covers the little-endian state the peripheral starts in: while it is set, the bytes inside each 16-bit half of the header, the write data and the returned word are exchanged.

Top module: `rac_seq`

## Requirements
- R1: The header is {write, 1, fn[1:0], addr[16:0], size[10:0]} from bit 31 down to bit 0. The address-increment bit 30 is always 1, and size is the request's unrounded byte count. Function codes: 0 bus, 1 backplane, 2 data.
- R2: A register read (req_block_i=0, req_write_i=0) starts one transfer with eng_tx_bytes_o=4 and eng_rx_bytes_o=8. The response data is the last word received.
- R3: Any read on function 1 adds PAD_BYTES (default 4) to eng_rx_bytes_o. Reads on other functions add nothing.
- R4: A register write starts one transfer with eng_tx_bytes_o=8 and eng_rx_bytes_o=0. eng_wdata_o carries req_data_i, and the response data is 0.
- R5: A block request rounds size up to a multiple of 4, giving L. A block write sends L+4 bytes and receives 0. A block read sends 4 bytes and receives L+4, plus padding per R3.
- R6: A request fails with rsp_err_o=1, rsp_data_o=0 and no engine start in these cases: size is 0, a register size is above 4, or a block's rounded length is above MAX_BLOCK (0x7F8).
- R7: With req_boot_i=1, the bytes in each 16-bit half are swapped: b3b2b1b0 becomes b2b3b0b1. This applies to the header, to eng_wdata_o, and to the returned data word.
- R8: Before any write on function 2, the block issues status reads {0,1,fn 0,STAT_ADDR,size 4}, with tx 4 and rx 8. It repeats them until bit READY_BIT (default 5) of the returned word is 1, then starts the write.
- R9: If MAX_POLLS (default 1000) status reads all return not-ready, the request fails with rsp_err_o=1 and the write is never started.
- R10: req_ready_o is high only while idle. Each accepted request produces exactly one single-cycle rsp_valid_o, and eng_start_o is always a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| req_ready_o | output | 1 | Block idle, request accepted on valid |
| req_write_i | input | 1 | 1 write, 0 read |
| req_block_i | input | 1 | 1 block transfer, 0 register access |
| req_fn_i | input | 2 | Function number |
| req_addr_i | input | 17 | Address |
| req_size_i | input | 11 | Byte count |
| req_data_i | input | 32 | Register write data |
| req_boot_i | input | 1 | Halfword byte-swap mode |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_data_o | output | 32 | Last received word (reads) or 0 |
| rsp_err_o | output | 1 | Request failed |
| eng_start_o | output | 1 | Start the engine |
| eng_hdr_o | output | 32 | Command header word |
| eng_wdata_o | output | 32 | Second transmit word |
| eng_tx_bytes_o | output | 12 | Bytes to send |
| eng_rx_bytes_o | output | 12 | Bytes to receive after the sent ones |
| eng_rx_valid_i | input | 1 | Received word strobe |
| eng_rx_word_i | input | 32 | Received word |
| eng_done_i | input | 1 | Engine finished |

## Verification
The assertions assume a well-behaved engine. It raises eng_done_i only after the start pulse has been seen, and no earlier than one cycle after its last eng_rx_valid_i, so the captured word is final when the block acts on it. The bench engine model waits one cycle after every start, streams exactly eng_rx_bytes_o/4 words, and only then pulses done. Request fields are held steady through the acceptance edge and are changed only while the block is idle.

// File: rtl/rac_pkg.sv
package rac_pkg;
  localparam logic [1:0] FN_BUS  = 2'd0;
  localparam logic [1:0] FN_BKPL = 2'd1;
  localparam logic [1:0] FN_DATA = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_POLL_GO, ST_POLL_WAIT, ST_XFER_GO, ST_XFER_WAIT, ST_DONE
  } rac_state_e;

  function automatic logic [31:0] hswap(input logic [31:0] w);
    return {w[23:16], w[31:24], w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/rac_hdr.sv
module rac_hdr
  import rac_pkg::*;
(
  input  logic        write_i,
  input  logic [1:0]  fn_i,
  input  logic [16:0] addr_i,
  input  logic [10:0] size_i,
  input  logic [31:0] data_i,
  input  logic        boot_i,
  output logic [31:0] hdr_o,
  output logic [31:0] data_o
);
  logic [31:0] raw;
  assign raw    = {write_i, 1'b1, fn_i, addr_i, size_i};
  assign hdr_o  = boot_i ? hswap(raw) : raw;
  assign data_o = boot_i ? hswap(data_i) : data_i;
endmodule

// File: rtl/rac_len.sv
module rac_len
  import rac_pkg::*;
#(
  parameter int PAD_BYTES = 4,
  parameter int MAX_BLOCK = 'h7F8,
  parameter int LEN_W     = 12
) (
  input  logic             write_i,
  input  logic             block_i,
  input  logic [1:0]       fn_i,
  input  logic [10:0]      size_i,
  output logic [LEN_W-1:0] tx_bytes_o,
  output logic [LEN_W-1:0] rx_bytes_o,
  output logic             ok_o
);
  localparam int REG_WORDS_B = 8;
  logic [LEN_W-1:0] aligned, pad;

  always_comb begin
    aligned = (LEN_W'(size_i) + LEN_W'(3)) & ~LEN_W'(3);
    pad     = (fn_i == FN_BKPL) ? LEN_W'(PAD_BYTES) : '0;
    if (block_i) begin
      ok_o       = (size_i != '0) && (aligned <= LEN_W'(MAX_BLOCK));
      tx_bytes_o = write_i ? aligned + LEN_W'(4) : LEN_W'(4);
      rx_bytes_o = write_i ? '0 : aligned + LEN_W'(4) + pad;
    end else begin
      ok_o       = (size_i != '0) && (size_i <= 11'd4);
      tx_bytes_o = write_i ? LEN_W'(REG_WORDS_B) : LEN_W'(4);
      rx_bytes_o = write_i ? '0 : LEN_W'(REG_WORDS_B) + pad;
    end
  end
endmodule

// File: rtl/rac_seq.sv
module rac_seq
  import rac_pkg::*;
#(
  parameter int          PAD_BYTES = 4,
  parameter int          MAX_BLOCK = 'h7F8,
  parameter int          MAX_POLLS = 1000,
  parameter int          READY_BIT = 5,
  parameter logic [16:0] STAT_ADDR = 17'h8,
  parameter int          LEN_W     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic             req_block_i,
  input  logic [1:0]       req_fn_i,
  input  logic [16:0]      req_addr_i,
  input  logic [10:0]      req_size_i,
  input  logic [31:0]      req_data_i,
  input  logic             req_boot_i,
  output logic             rsp_valid_o,
  output logic [31:0]      rsp_data_o,
  output logic             rsp_err_o,
  output logic             eng_start_o,
  output logic [31:0]      eng_hdr_o,
  output logic [31:0]      eng_wdata_o,
  output logic [LEN_W-1:0] eng_tx_bytes_o,
  output logic [LEN_W-1:0] eng_rx_bytes_o,
  input  logic             eng_rx_valid_i,
  input  logic [31:0]      eng_rx_word_i,
  input  logic             eng_done_i
);
  localparam int PC_W = $clog2(MAX_POLLS + 1);

  rac_state_e state_q;
  logic        wr_q, blk_q, boot_q;
  logic [1:0]  fn_q;
  logic [16:0] addr_q;
  logic [10:0] size_q;
  logic [31:0] data_q, rx_last_q, rx_res;
  logic [PC_W-1:0] poll_cnt_q;

  logic             polling;
  logic             h_wr;
  logic [1:0]       h_fn;
  logic [16:0]      h_addr;
  logic [10:0]      h_size;
  logic [LEN_W-1:0] tx_len, rx_len;
  logic             len_ok;

  assign polling = (state_q == ST_POLL_GO) || (state_q == ST_POLL_WAIT);
  assign h_wr    = polling ? 1'b0 : wr_q;
  assign h_fn    = polling ? FN_BUS : fn_q;
  assign h_addr  = polling ? STAT_ADDR : addr_q;
  assign h_size  = polling ? 11'd4 : size_q;

  rac_hdr u_hdr (
    .write_i(h_wr), .fn_i(h_fn), .addr_i(h_addr), .size_i(h_size),
    .data_i(data_q), .boot_i(boot_q), .hdr_o(eng_hdr_o), .data_o(eng_wdata_o)
  );

  rac_len #(.PAD_BYTES(PAD_BYTES), .MAX_BLOCK(MAX_BLOCK), .LEN_W(LEN_W)) u_len (
    .write_i(wr_q), .block_i(blk_q), .fn_i(fn_q), .size_i(size_q),
    .tx_bytes_o(tx_len), .rx_bytes_o(rx_len), .ok_o(len_ok)
  );

  assign eng_tx_bytes_o = polling ? LEN_W'(4) : tx_len;
  assign eng_rx_bytes_o = polling ? LEN_W'(8) : rx_len;
  assign eng_start_o    = (state_q == ST_POLL_GO) || (state_q == ST_XFER_GO);
  assign req_ready_o    = (state_q == ST_IDLE);
  assign rsp_valid_o    = (state_q == ST_DONE);
  assign rx_res         = boot_q ? hswap(rx_last_q) : rx_last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_last_q <= '0;
    else if (eng_rx_valid_i) rx_last_q <= eng_rx_word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      wr_q       <= 1'b0;
      blk_q      <= 1'b0;
      boot_q     <= 1'b0;
      fn_q       <= '0;
      addr_q     <= '0;
      size_q     <= '0;
      data_q     <= '0;
      poll_cnt_q <= '0;
      rsp_data_o <= '0;
      rsp_err_o  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          wr_q    <= req_write_i;
          blk_q   <= req_block_i;
          fn_q    <= req_fn_i;
          addr_q  <= req_addr_i;
          size_q  <= req_size_i;
          data_q  <= req_data_i;
          boot_q  <= req_boot_i;
          state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          poll_cnt_q <= '0;
          rsp_data_o <= '0;
          rsp_err_o  <= 1'b0;
          if (!len_ok) begin
            rsp_err_o <= 1'b1;
            state_q   <= ST_DONE;
          end else if (wr_q && fn_q == FN_DATA) state_q <= ST_POLL_GO;
          else state_q <= ST_XFER_GO;
        end
        ST_POLL_GO: state_q <= ST_POLL_WAIT;
        ST_POLL_WAIT: if (eng_done_i) begin
          if (rx_res[READY_BIT]) state_q <= ST_XFER_GO;
          else if (poll_cnt_q == PC_W'(MAX_POLLS - 1)) begin
            rsp_err_o <= 1'b1;
            state_q   <= ST_DONE;
          end else begin
            poll_cnt_q <= poll_cnt_q + 1'b1;
            state_q    <= ST_POLL_GO;
          end
        end
        ST_XFER_GO: state_q <= ST_XFER_WAIT;
        ST_XFER_WAIT: if (eng_done_i) begin
          rsp_data_o <= wr_q ? '0 : rx_res;
          state_q    <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_start_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |=> !eng_start_o);
  p_rsp_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);
  p_len_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CHECK && !len_ok) |=> rsp_valid_o && rsp_err_o && !eng_start_o);
  p_word_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_start_o |-> (eng_tx_bytes_o[1:0] == 2'b00) && (eng_rx_bytes_o[1:0] == 2'b00));
  p_write_no_rx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_start_o && !polling && wr_q) |-> eng_rx_bytes_o == '0);
  p_poll_bound_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poll_cnt_q < PC_W'(MAX_POLLS));
  p_poll_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_POLL_WAIT && eng_done_i && rx_res[READY_BIT]) |=> eng_start_o && !polling);
endmodule

// File: tb/rac_seq_tb.sv
module rac_seq_tb_top;
  import rac_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_write = 0, req_block = 0, req_boot = 0;
  logic [1:0]  req_fn = 0;
  logic [16:0] req_addr = 0;
  logic [10:0] req_size = 0;
  logic [31:0] req_data = 0;
  logic        req_ready, rsp_valid, rsp_err, eng_start;
  logic [31:0] rsp_data, eng_hdr, eng_wdata;
  logic [11:0] eng_tx, eng_rx;
  logic        eng_rx_valid = 0, eng_done = 0;
  logic [31:0] eng_rx_word = 0;

  rac_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_block_i(req_block), .req_fn_i(req_fn),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_data_i(req_data),
    .req_boot_i(req_boot), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .rsp_err_o(rsp_err), .eng_start_o(eng_start), .eng_hdr_o(eng_hdr),
    .eng_wdata_o(eng_wdata), .eng_tx_bytes_o(eng_tx), .eng_rx_bytes_o(eng_rx),
    .eng_rx_valid_i(eng_rx_valid), .eng_rx_word_i(eng_rx_word), .eng_done_i(eng_done)
  );

  localparam logic [31:0] LASTW = 32'hC0DE_1234;
  localparam logic [31:0] POLL_HDR = {1'b0, 1'b1, 2'd0, 17'h8, 11'd4};

  int total = 0, bad = 0;
  int n_starts = 0, n_polls = 0, poll_need = 0;
  logic [31:0] last_hdr, last_wdata;
  logic [11:0] last_tx, last_rx;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // engine model: everything at the falling edge
  initial begin
    @(negedge clk);
    forever begin
      if (eng_start) begin
        int nw;
        logic [31:0] resp;
        n_starts++;
        last_hdr = eng_hdr; last_wdata = eng_wdata; last_tx = eng_tx; last_rx = eng_rx;
        nw = int'(eng_rx) / 4;
        if (eng_hdr == POLL_HDR || eng_hdr == hswap(POLL_HDR)) begin
          resp = (n_polls >= poll_need) ? 32'h20 : 32'h0;
          if (eng_hdr != POLL_HDR) resp = hswap(resp);
          n_polls++;
        end else resp = LASTW;
        @(negedge clk);
        for (int i = 0; i < nw; i++) begin
          eng_rx_valid = 1; eng_rx_word = (i == nw - 1) ? resp : 32'h5A00_0000 + i;
          @(negedge clk);
        end
        eng_rx_valid = 0; eng_done = 1;
        @(negedge clk);
        eng_done = 0;
      end else @(negedge clk);
    end
  end

  logic got_err;
  logic [31:0] got_data;
  task automatic do_req(input logic wr, blk, input logic [1:0] fn, input logic [16:0] addr,
                        input logic [10:0] size, input logic [31:0] data, input logic boot);
    int t = 0;
    @(negedge clk);
    req_write = wr; req_block = blk; req_fn = fn; req_addr = addr;
    req_size = size; req_data = data; req_boot = boot; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid && t < 20000) begin @(negedge clk); t++; end
    got_err = rsp_err; got_data = rsp_data;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R10 single response", {30'd0, req_ready, rsp_valid}, 32'h2);
  endtask

  typedef struct packed {
    logic wr; logic blk; logic [1:0] fn; logic [16:0] addr; logic [10:0] size;
    logic [31:0] data; logic boot; logic [3:0] polls; logic err;
    logic [11:0] tx; logic [11:0] rx; logic [3:0] starts;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t V [NV] = '{
    '{0,0,2'd0,17'h14,   11'd4,     32'h0,         0,4'd0,0,12'd4,  12'd8,    4'd1}, // R2
    '{0,0,2'd1,17'h1FFFF,11'd2,     32'h0,         0,4'd0,0,12'd4,  12'd12,   4'd1}, // R3 reg pad
    '{1,0,2'd1,17'h1000, 11'd4,     32'h11223344,  0,4'd0,0,12'd8,  12'd0,    4'd1}, // R4
    '{1,0,2'd0,17'h14,   11'd4,     32'hAABBCCDD,  1,4'd0,0,12'd8,  12'd0,    4'd1}, // R7 write
    '{0,0,2'd0,17'h2C,   11'd4,     32'h0,         1,4'd0,0,12'd4,  12'd8,    4'd1}, // R7 read
    '{0,1,2'd2,17'h0,    11'd5,     32'h0,         0,4'd0,0,12'd4,  12'd12,   4'd1}, // R5 round
    '{0,1,2'd1,17'h40,   11'h7F8,   32'h0,         0,4'd0,0,12'd4,  12'h800,  4'd1}, // R3 R5 max
    '{1,1,2'd1,17'h80,   11'd13,    32'h0,         0,4'd0,0,12'd20, 12'd0,    4'd1}, // R5 write
    '{1,1,2'd2,17'h10,   11'd4,     32'h0,         0,4'd0,0,12'd8,  12'd0,    4'd2}, // R8 ready
    '{0,1,2'd1,17'h0,    11'h7F9,   32'h0,         0,4'd0,1,12'd0,  12'd0,    4'd0}, // R6 long
    '{0,0,2'd0,17'h0,    11'd0,     32'h0,         0,4'd0,1,12'd0,  12'd0,    4'd0}, // R6 zero
    '{1,0,2'd0,17'h0,    11'd5,     32'h0,         0,4'd0,1,12'd0,  12'd0,    4'd0}, // R6 reg size
    '{1,0,2'd2,17'h1234, 11'd4,     32'hCAFEF00D,  0,4'd3,0,12'd8,  12'd0,    4'd5}  // R8 retries
  };

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state, R10
    chk(req_ready && !rsp_valid && !eng_start, "R10 reset", {29'd0, req_ready, rsp_valid, eng_start}, 32'h4);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !eng_start && rsp_data == 0, "R10 after reset",
        {29'd0, req_ready, rsp_valid, eng_start}, 32'h4);

    for (int k = 0; k < NV; k++) begin
      int s0;
      logic [31:0] eh, ed;
      s0 = n_starts; n_polls = 0; poll_need = int'(V[k].polls);
      do_req(V[k].wr, V[k].blk, V[k].fn, V[k].addr, V[k].size, V[k].data, V[k].boot);
      eh = {V[k].wr, 1'b1, V[k].fn, V[k].addr, V[k].size};
      if (V[k].boot) eh = hswap(eh);
      ed = (V[k].err || V[k].wr) ? 32'h0 : (V[k].boot ? hswap(LASTW) : LASTW);
      chk(got_err == V[k].err, "R6 error flag", {31'd0, got_err}, {31'd0, V[k].err});
      chk(got_data == ed, V[k].boot ? "R7 response data" : "R2 response data", got_data, ed);
      chk(n_starts - s0 == int'(V[k].starts), "R8 engine start count", n_starts - s0, V[k].starts);
      if (!V[k].err) begin
        chk(last_hdr == eh, V[k].boot ? "R7 header" : "R1 header", last_hdr, eh);
        chk(last_tx == V[k].tx, "R5 tx bytes", last_tx, V[k].tx);
        chk(last_rx == V[k].rx, "R3 rx bytes", last_rx, V[k].rx);
        if (V[k].wr && !V[k].blk) begin
          ed = V[k].boot ? hswap(V[k].data) : V[k].data;
          chk(last_wdata == ed, "R4 write data", last_wdata, ed);
        end
      end
    end

    // R9: status never ready, write must not start
    begin
      int s0;
      s0 = n_starts; n_polls = 0; poll_need = 100000;
      do_req(1, 0, 2'd2, 17'h44, 11'd4, 32'h1, 0);
      chk(got_err == 1'b1, "R9 error on exhaustion", {31'd0, got_err}, 1);
      chk(n_starts - s0 == 1000, "R9 poll count", n_starts - s0, 1000);
      chk(last_hdr == POLL_HDR && last_tx == 4 && last_rx == 8, "R8 poll transfer shape", last_hdr, POLL_HDR);
    end

    // R8 in boot mode: poll header swapped, ready on second read
    begin
      int s0;
      s0 = n_starts; n_polls = 0; poll_need = 1;
      do_req(1, 0, 2'd2, 17'h48, 11'd4, 32'h01020304, 1);
      chk(got_err == 1'b0 && n_starts - s0 == 3, "R8 boot polling", n_starts - s0, 3);
      chk(last_wdata == 32'h02010403, "R7 boot write data", last_wdata, 32'h02010403);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule